// File: doc/BRIEF.md
# Ticket Lock Unit

A hardware lock that serves a fixed set of requesters strictly in arrival order. It keeps two wrapping counters. One is a dispenser that counts the tickets handed out. The other is a serving counter that counts completed releases. A requester pulses its acquire line and receives the current dispenser value as its ticket, and the dispenser advances atomically. A requester owns the lock while the serving counter equals its ticket. When the owner pulses its release line, the serving counter steps by one and the lock passes to the next ticket.

Because the dispenser fixes the order when each request arrives, every requester is served once all earlier tickets have been released, and nobody starves. When several requesters acquire in the same cycle, they receive consecutive tickets, lowest index first. Each waiting requester also gets a distance hint that says how many holders are ahead of it, for use in sizing a poll delay. A release from a requester that does not own the lock is reported on an error output and has no other effect.

Top module: `ticket_lock`

## Requirements
- R1: After reset the serving count is 0, no requester holds a ticket or the lock, and the error output is 0.
- R2: An acquire from a requester with no ticket returns the dispenser value as its ticket, visible one cycle later, and advances the dispenser by one.
- R3: Acquires that arrive in the same cycle get consecutive tickets in ascending requester index, the lowest index taking the lowest ticket.
- R4: `grant_o[i]` is 1 exactly when requester i holds a ticket equal to the serving count, so at most one grant is active at a time.
- R5: A release from the granted requester increments the serving count by one in the next cycle and clears that requester's ticket.
- R6: The lock is granted in ticket order, so requesters are served in the order they acquired.
- R7: A release from a requester that is not granted sets its bit of `rel_err_o` for one cycle after the release and leaves the serving count and all grants unchanged.
- R8: An acquire from a requester that already holds a ticket is ignored: its ticket and the dispenser stay unchanged.
- R9: Both counters are `TKT_W` bits wide and wrap modulo 2^TKT_W. Ticket 2^TKT_W-1 is followed by ticket 0.
- R10: `hint_o[i]` equals (ticket − serving) mod 2^TKT_W while requester i waits, and 0 while it holds no ticket or is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acq_i | input | NUM_REQ | Per-requester acquire pulse |
| rel_i | input | NUM_REQ | Per-requester release pulse |
| held_o | output | NUM_REQ | Requester holds a ticket (waiting or granted) |
| ticket_o | output | NUM_REQ*TKT_W | Ticket of each requester, requester i at bits [i*TKT_W +: TKT_W] |
| grant_o | output | NUM_REQ | Requester owns the lock |
| hint_o | output | NUM_REQ*TKT_W | Tickets ahead of each waiting requester, same packing as ticket_o |
| serving_o | output | TKT_W | Current serving count |
| rel_err_o | output | NUM_REQ | One-cycle flag for a release from a non-owner |

## Verification
The hardest case to reach is counter wrap. At most NUM_REQ tickets are outstanding, so both counters can cross 2^TKT_W only after many full acquire–release rounds. The stimulus runs a single requester through back-to-back acquire and release cycles until the dispenser passes 15 and returns to 0, checking the ticket and the immediate grant at every step. Simultaneous multi-requester acquires, acquires from requesters that already hold a ticket, and releases from non-owners are each driven while other tickets are outstanding, so that order and ignored effects show up at the ports.

// File: rtl/ticket_lock_pkg.sv
package ticket_lock_pkg;
  function automatic int unsigned tl_min_width(input int unsigned n);
    return $clog2(n) + 1;
  endfunction
endpackage

// File: rtl/tkt_dispenser.sv
module tkt_dispenser #(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned TKT_W   = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_REQ-1:0]              take_i,
  output logic [NUM_REQ-1:0][TKT_W-1:0]   offer_o
);
  logic [TKT_W-1:0] next_q, next_d;

  // prefix allocation: lower index draws the lower ticket
  always_comb begin
    logic [TKT_W-1:0] run;
    run = next_q;
    for (int i = 0; i < NUM_REQ; i++) begin
      offer_o[i] = run;
      run = run + TKT_W'(take_i[i]);
    end
    next_d = run;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) next_q <= '0;
    else         next_q <= next_d;
  end

  p_next_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> next_q == TKT_W'($past(next_q) + TKT_W'($countones($past(take_i)))));
endmodule

// File: rtl/tkt_slot.sv
module tkt_slot #(
  parameter int unsigned TKT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [TKT_W-1:0] offer_i,
  input  logic [TKT_W-1:0] serving_i,
  input  logic             rel_i,
  output logic             held_o,
  output logic [TKT_W-1:0] ticket_o,
  output logic             grant_o,
  output logic [TKT_W-1:0] hint_o,
  output logic             done_o
);
  logic             held_q;
  logic [TKT_W-1:0] ticket_q;

  assign grant_o  = held_q && (ticket_q == serving_i);
  assign done_o   = rel_i && grant_o;
  assign held_o   = held_q;
  assign ticket_o = ticket_q;
  assign hint_o   = (held_q && !grant_o) ? TKT_W'(ticket_q - serving_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q   <= 1'b0;
      ticket_q <= '0;
    end else if (done_o) begin
      held_q   <= 1'b0;
    end else if (take_i) begin
      held_q   <= 1'b1;
      ticket_q <= offer_i;
    end
  end

  p_ticket_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q && !done_o |=> held_q && $stable(ticket_q));
  p_take_needs_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> !held_q);
endmodule

// File: rtl/tkt_server.sv
module tkt_server #(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned TKT_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] done_i,
  input  logic [NUM_REQ-1:0] rel_i,
  input  logic [NUM_REQ-1:0] grant_i,
  output logic [TKT_W-1:0]   serving_o,
  output logic [NUM_REQ-1:0] rel_err_o
);
  logic [TKT_W-1:0]   serving_q;
  logic [NUM_REQ-1:0] err_q;
  logic               adv;

  assign adv       = |done_i;
  assign serving_o = serving_q;
  assign rel_err_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      serving_q <= '0;
      err_q     <= '0;
    end else begin
      if (adv) serving_q <= serving_q + 1'b1;
      err_q <= rel_i & ~grant_i;
    end
  end

  p_one_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_i));
  p_serving_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> serving_q == TKT_W'($past(serving_q) + 1'b1));
  p_serving_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv |=> $stable(serving_q));
endmodule

// File: rtl/ticket_lock.sv
module ticket_lock
  import ticket_lock_pkg::*;
#(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned TKT_W   = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_REQ-1:0]       acq_i,
  input  logic [NUM_REQ-1:0]       rel_i,
  output logic [NUM_REQ-1:0]       held_o,
  output logic [NUM_REQ*TKT_W-1:0] ticket_o,
  output logic [NUM_REQ-1:0]       grant_o,
  output logic [NUM_REQ*TKT_W-1:0] hint_o,
  output logic [TKT_W-1:0]         serving_o,
  output logic [NUM_REQ-1:0]       rel_err_o
);
  localparam int unsigned MIN_W = tl_min_width(NUM_REQ);
  localparam bit          W_OK  = (TKT_W >= MIN_W);

  logic [NUM_REQ-1:0]            take, done, held, grant;
  logic [NUM_REQ-1:0][TKT_W-1:0] offer;
  logic [TKT_W-1:0]              serving;

  assign take = acq_i & ~held;

  tkt_dispenser #(.NUM_REQ(NUM_REQ), .TKT_W(TKT_W)) u_disp (
    .clk_i, .rst_ni, .take_i(take), .offer_o(offer)
  );

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_slot
    tkt_slot #(.TKT_W(TKT_W)) u_slot (
      .clk_i, .rst_ni,
      .take_i   (take[i]),
      .offer_i  (offer[i]),
      .serving_i(serving),
      .rel_i    (rel_i[i]),
      .held_o   (held[i]),
      .ticket_o (ticket_o[i*TKT_W +: TKT_W]),
      .grant_o  (grant[i]),
      .hint_o   (hint_o[i*TKT_W +: TKT_W]),
      .done_o   (done[i])
    );
  end

  tkt_server #(.NUM_REQ(NUM_REQ), .TKT_W(TKT_W)) u_srv (
    .clk_i, .rst_ni,
    .done_i   (done),
    .rel_i    (rel_i),
    .grant_i  (grant),
    .serving_o(serving),
    .rel_err_o(rel_err_o)
  );

  assign held_o    = held;
  assign grant_o   = grant;
  assign serving_o = serving;

  p_width_ok_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    W_OK || !(|held));
  p_single_grant_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  p_grant_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant & ~held) == '0);
  p_err_no_grant_move_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(rel_i & grant)) && !(|take) |=> $stable(grant));
endmodule

// File: tb/tb_ticket_lock.sv
module tb_ticket_lock;
  localparam int N = 4;
  localparam int W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] acq = '0, rel = '0;
  logic [N-1:0] held, grant, rel_err;
  logic [N*W-1:0] ticket, hint;
  logic [W-1:0] serving;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ticket_lock #(.NUM_REQ(N), .TKT_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .acq_i(acq), .rel_i(rel),
    .held_o(held), .ticket_o(ticket), .grant_o(grant), .hint_o(hint),
    .serving_o(serving), .rel_err_o(rel_err)
  );

  // {acq, rel, expected grant, expected serving}
  localparam logic [15:0] VEC [0:8] = '{
    16'h1010, 16'hE010, 16'h0121, 16'h0421, 16'h1021,
    16'h0242, 16'h0483, 16'h0814, 16'h0105
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] a, input logic [N-1:0] r);
    @(negedge clk);
    acq = a; rel = r;
    @(posedge clk);
    #2;
    acq = '0; rel = '0;
  endtask

  function automatic int tk(input int i);
    return int'(ticket[i*W +: W]);
  endfunction
  function automatic int hn(input int i);
    return int'(hint[i*W +: W]);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; acq = '0; rel = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1 serving", int'(serving), 0);
    chk("R1 held",    int'(held), 0);
    chk("R1 grant",   int'(grant), 0);
    chk("R1 rel_err", int'(rel_err), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    do_reset();

    // R4 R5 R6: table walk
    for (int v = 0; v < 9; v++) begin
      step(VEC[v][15:12], VEC[v][11:8]);
      chk($sformatf("R4/R6 grant vec%0d", v), int'(grant), int'(VEC[v][7:4]));
      chk($sformatf("R5 serving vec%0d", v), int'(serving), int'(VEC[v][3:0]));
    end

    do_reset();
    // R3: simultaneous acquires, index order
    step(4'b0110, '0);
    chk("R3 ticket r1", tk(1), 0);
    chk("R3 ticket r2", tk(2), 1);
    chk("R4 grant r1",  int'(grant), 2);
    chk("R10 hint r2",  hn(2), 1);
    chk("R10 hint r1 granted", hn(1), 0);
    chk("R10 hint r0 idle", hn(0), 0);

    // R8: r1 already holds; R2: r3 draws next dispenser value
    step(4'b1010, '0);
    chk("R8 ticket r1 kept", tk(1), 0);
    chk("R2 ticket r3", tk(3), 2);
    chk("R10 hint r3", hn(3), 2);

    // R7: release from non-owner
    step('0, 4'b0001);
    chk("R7 rel_err", int'(rel_err), 1);
    chk("R7 serving", int'(serving), 0);
    chk("R7 grant",   int'(grant), 2);
    step('0, '0);
    chk("R7 err one cycle", int'(rel_err), 0);

    step('0, 4'b0010);
    chk("R5 serving 1", int'(serving), 1);
    chk("R5 r1 cleared", int'(held[1]), 0);
    chk("R10 hint r3 after", hn(3), 1);
    step('0, 4'b0100);
    step('0, 4'b1000);
    chk("R5 serving 3", int'(serving), 3);
    chk("R5 no grant", int'(grant), 0);

    // R9: wrap with one requester cycling
    for (int k = 0; k < 14; k++) begin
      step(4'b0001, '0);
      chk($sformatf("R9 ticket k%0d", k), tk(0), (3 + k) % 16);
      chk($sformatf("R4 grant k%0d", k), int'(grant), 1);
      step('0, 4'b0001);
      chk($sformatf("R9 serving k%0d", k), int'(serving), (4 + k) % 16);
    end

    finish_run();
  end
endmodule